// File: doc/BRIEF.md
# Panel Timing Compliance Monitor

This block watches the horizontal sync, vertical sync and data-enable signals of a display panel on the pixel clock. It catches the timing faults that make such a panel go dark or put it at risk. For every line it measures the clock count and the active width. For every frame it measures the line count, the active height, the total clocks and the number of lines from the vertical sync to the first active line. Each measurement is checked against fixed limits and against the previous measurement of the same kind. The block also checks that vertical blanking is a whole number of lines, that there is enough setup time between a vertical sync edge and the next horizontal sync edge, and that data-enable keeps toggling.

The block only observes. Each kind of fault has its own sticky flag. A one-cycle pulse marks every new fault, and the most recent measurements are available at the outputs. The inputs carry no handshake, so every pin is a plain level. Sync pulses are taken as active high, and each period is measured from one rising edge to the next. The inputs pass through a two-register stage, so a fault shows on the flags and on the pulse two clock edges after the input edge that completes it.

Top module: `panel_timing_monitor`

## Requirements
- R1: After reset, `err_flags`, `err_pulse` and all four measurement outputs are zero.
- R2: Flag bit 0 is set when a line's clock count (rising hsync edge to rising hsync edge) differs from the line measured just before it.
- R3: Flag bit 1 is set when a line's clock count is below `LINE_MIN` or above `LINE_MAX`.
- R4: Flag bit 7 is set when a data-enable high run does not last exactly `ACT_W` clocks.
- R5: Flag bit 2 is set when the number of hsync rising edges between two vsync rising edges is below `FRAME_MIN` or above `FRAME_MAX`.
- R6: Flag bit 8 is set when the number of data-enable high runs between two vsync rising edges is not `ACT_H`.
- R7: Flag bit 3 is set when the frame length in clocks, or the number of hsync rising edges from a vsync rising edge to the frame's first data-enable rise, differs from the value of the previous complete frame. The partial frame before the first vsync rise is not measured.
- R8: Flag bit 4 is set when a frame's first data-enable rise is not a whole number of measured line lengths after the previous data-enable rise.
- R9: Flag bit 5 is set when an hsync edge (either direction) follows a vsync edge (either direction) by fewer than `SETUP_MIN` clocks.
- R10: Flag bit 6 is set once when data-enable has not changed for `STUCK_CLKS` clocks. It is not set again until data-enable has toggled.
- R11: Flags stay set until `clr` is high for one cycle, and `clr` then returns them to zero. A fault in the same cycle as `clr` still sets its flag. `err_pulse` is high for one cycle for each clock cycle in which at least one fault occurs.
- R12: The outputs carry the most recent line clock count, active width, frame line count and active height.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync | input | 1 | Horizontal sync, active high |
| vsync | input | 1 | Vertical sync, active high |
| de | input | 1 | Data enable |
| clr | input | 1 | Clears all sticky flags |
| err_flags | output | 9 | Sticky fault flags, bit map as in the requirements |
| err_pulse | output | 1 | One-cycle pulse for each cycle with a new fault |
| meas_line_clks | output | $clog2(LINE_MAX+1)+1 | Last line length in clocks |
| meas_act_width | output | $clog2(LINE_MAX+1)+1 | Last data-enable run length |
| meas_frame_lines | output | $clog2(FRAME_MAX+1)+1 | Last frame length in lines |
| meas_act_height | output | $clog2(FRAME_MAX+1)+1 | Last active line count |

## Verification
A line counter that is off by one shows up on the next hsync rise. The constancy or range flag trips, and `meas_line_clks` takes the wrong value within one line. A vertical phase counter that has drifted raises the blanking flag at the next frame's first active line, even when line lengths and frame lengths are clean. A stored frame reference that is corrupted stays silent until the following vsync rise, so it takes up to two frames to show. The bench therefore runs four frames in each scenario and compares the exact flag word and the pulse count.

// File: rtl/ptm_pkg.sv
package ptm_pkg;
  localparam int NUM_ERR       = 9;
  localparam int E_LINE_CHG    = 0;
  localparam int E_LINE_RANGE  = 1;
  localparam int E_FRAME_RANGE = 2;
  localparam int E_VTIME_CHG   = 3;
  localparam int E_VBLANK      = 4;
  localparam int E_SETUP       = 5;
  localparam int E_DE_STUCK    = 6;
  localparam int E_ACT_W       = 7;
  localparam int E_ACT_H       = 8;
  typedef logic [NUM_ERR-1:0] err_vec_t;
endpackage

// File: rtl/ptm_hmeas.sv
module ptm_hmeas #(
  parameter int ACT_W    = 1024,
  parameter int LINE_MIN = 1334,
  parameter int LINE_MAX = 1344,
  parameter int CW       = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hs_rise,
  input  logic          de_lvl,
  input  logic          de_rise,
  input  logic          de_fall,
  output logic [CW-1:0] line_len,
  output logic          line_ok,
  output logic [CW-1:0] act_width,
  output logic          ev_line_chg,
  output logic          ev_line_range,
  output logic          ev_act_w
);
  logic [CW-1:0] line_cnt, de_cnt;
  logic          have_line, have_de;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_cnt  <= '0;
      de_cnt    <= '0;
      have_line <= 1'b0;
      have_de   <= 1'b0;
      line_len  <= '0;
      line_ok   <= 1'b0;
      act_width <= '0;
    end else begin
      if (hs_rise) begin
        line_cnt  <= CW'(1);
        have_line <= 1'b1;
        if (have_line) begin
          line_len <= line_cnt;
          line_ok  <= 1'b1;
        end
      end else if (line_cnt != '1) begin
        line_cnt <= line_cnt + 1'b1;
      end
      if (de_rise) begin
        de_cnt  <= CW'(1);
        have_de <= 1'b1;
      end else if (de_lvl && de_cnt != '1) begin
        de_cnt <= de_cnt + 1'b1;
      end
      if (de_fall && have_de) act_width <= de_cnt;
    end
  end

  always_comb begin
    ev_line_range = hs_rise && have_line &&
                    (line_cnt < CW'(LINE_MIN) || line_cnt > CW'(LINE_MAX));
    ev_line_chg   = hs_rise && have_line && line_ok && (line_cnt != line_len);
    ev_act_w      = de_fall && have_de && (de_cnt != CW'(ACT_W));
  end

  a_r2_len_held: assert property (@(posedge clk) disable iff (!rst_n)
    !hs_rise |=> $stable(line_len));
  a_r4_width_held: assert property (@(posedge clk) disable iff (!rst_n)
    !de_fall |=> $stable(act_width));
  a_r12_valid_needs_line: assert property (@(posedge clk) disable iff (!rst_n)
    line_ok |-> have_line);
endmodule

// File: rtl/ptm_vmeas.sv
module ptm_vmeas #(
  parameter int ACT_H     = 768,
  parameter int FRAME_MIN = 778,
  parameter int FRAME_MAX = 860,
  parameter int CW        = 12,
  parameter int LW        = 11,
  parameter int FCW       = 22
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hs_rise,
  input  logic          vs_rise,
  input  logic          de_rise,
  input  logic [CW-1:0] line_len,
  input  logic          line_ok,
  output logic [LW-1:0] frame_lines,
  output logic [LW-1:0] act_height,
  output logic          ev_frame_range,
  output logic          ev_act_h,
  output logic          ev_vtime_chg,
  output logic          ev_vblank
);
  logic [LW-1:0]  lcnt, hcnt, vds_cnt, prev_vds;
  logic [FCW-1:0] fclk, prev_fclk;
  logic [CW-1:0]  phase;
  logic           got_de, frame_seen, frame_ok, vds_ok, de_seen;
  logic           first_de, fclk_chg, vds_chg;

  assign first_de = de_rise && frame_seen && !got_de && !vs_rise;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lcnt <= '0; hcnt <= '0; vds_cnt <= '0; prev_vds <= '0;
      fclk <= '0; prev_fclk <= '0; phase <= '0;
      got_de <= 1'b0; frame_seen <= 1'b0; frame_ok <= 1'b0;
      vds_ok <= 1'b0; de_seen <= 1'b0;
      frame_lines <= '0; act_height <= '0;
    end else begin
      if (vs_rise) begin
        lcnt       <= '0;
        hcnt       <= '0;
        vds_cnt    <= '0;
        fclk       <= FCW'(1);
        got_de     <= 1'b0;
        frame_seen <= 1'b1;
        if (frame_seen) begin
          frame_lines <= lcnt;
          act_height  <= hcnt;
          prev_fclk   <= fclk;
          frame_ok    <= 1'b1;
        end
      end else begin
        if (hs_rise && lcnt != '1) lcnt <= lcnt + 1'b1;
        if (de_rise && hcnt != '1) hcnt <= hcnt + 1'b1;
        if (fclk != '1) fclk <= fclk + 1'b1;
        if (hs_rise && !got_de && vds_cnt != '1) vds_cnt <= vds_cnt + 1'b1;
      end
      if (first_de) begin
        got_de   <= 1'b1;
        prev_vds <= vds_cnt;
        vds_ok   <= 1'b1;
      end
      if (de_rise) begin
        phase   <= CW'(1);
        de_seen <= 1'b1;
      end else if (phase >= line_len) begin
        phase <= CW'(1);
      end else begin
        phase <= phase + 1'b1;
      end
    end
  end

  always_comb begin
    ev_frame_range = vs_rise && frame_seen &&
                     (lcnt < LW'(FRAME_MIN) || lcnt > LW'(FRAME_MAX));
    ev_act_h       = vs_rise && frame_seen && (hcnt != LW'(ACT_H));
    fclk_chg       = vs_rise && frame_seen && frame_ok && (fclk != prev_fclk);
    vds_chg        = first_de && vds_ok && (vds_cnt != prev_vds);
    ev_vtime_chg   = fclk_chg || vds_chg;
    ev_vblank      = first_de && de_seen && line_ok && (phase != line_len);
  end

  a_r5_lines_held: assert property (@(posedge clk) disable iff (!rst_n)
    !vs_rise |=> $stable(frame_lines));
  a_r7_ref_after_seen: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok |-> frame_seen);
  a_r6_height_held: assert property (@(posedge clk) disable iff (!rst_n)
    !vs_rise |=> $stable(act_height));
endmodule

// File: rtl/ptm_setup.sv
module ptm_setup #(
  parameter int SETUP_MIN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vs_edge,
  input  logic hs_edge,
  output logic ev_setup
);
  localparam int SW = $clog2(SETUP_MIN + 1);
  logic [SW-1:0] cnt;
  logic          armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (vs_edge) begin
      cnt   <= SW'(1);
      armed <= !hs_edge;
    end else begin
      if (hs_edge) armed <= 1'b0;
      if (cnt != SW'(SETUP_MIN)) cnt <= cnt + 1'b1;
    end
  end

  assign ev_setup = hs_edge && (vs_edge || (armed && cnt < SW'(SETUP_MIN)));

  a_r9_disarm_on_hs: assert property (@(posedge clk) disable iff (!rst_n)
    hs_edge |=> !armed);
endmodule

// File: rtl/ptm_destuck.sv
module ptm_destuck #(
  parameter int STUCK_CLKS = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic de_chg,
  output logic ev_stuck
);
  localparam int DW = $clog2(STUCK_CLKS + 1);
  logic [DW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                     cnt <= '0;
    else if (de_chg)                cnt <= '0;
    else if (cnt != DW'(STUCK_CLKS)) cnt <= cnt + 1'b1;
  end

  assign ev_stuck = !de_chg && (cnt == DW'(STUCK_CLKS - 1));

  a_r10_single_shot: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stuck |=> !ev_stuck);
endmodule

// File: rtl/panel_timing_monitor.sv
module panel_timing_monitor
  import ptm_pkg::*;
#(
  parameter int ACT_W      = 1024,
  parameter int ACT_H      = 768,
  parameter int LINE_MIN   = 1334,
  parameter int LINE_MAX   = 1344,
  parameter int FRAME_MIN  = 778,
  parameter int FRAME_MAX  = 860,
  parameter int SETUP_MIN  = 8,
  parameter int STUCK_CLKS = 2 * LINE_MAX * FRAME_MAX
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           hsync,
  input  logic                           vsync,
  input  logic                           de,
  input  logic                           clr,
  output logic [NUM_ERR-1:0]             err_flags,
  output logic                           err_pulse,
  output logic [$clog2(LINE_MAX+1):0]    meas_line_clks,
  output logic [$clog2(LINE_MAX+1):0]    meas_act_width,
  output logic [$clog2(FRAME_MAX+1):0]   meas_frame_lines,
  output logic [$clog2(FRAME_MAX+1):0]   meas_act_height
);
  localparam int CW  = $clog2(LINE_MAX + 1) + 1;
  localparam int LW  = $clog2(FRAME_MAX + 1) + 1;
  localparam int FCW = $clog2(LINE_MAX * FRAME_MAX + 1) + 1;

  logic s_hs, s_vs, s_de, q_hs, q_vs, q_de;
  logic hs_rise, hs_edge, vs_rise, vs_edge, de_rise, de_fall, de_chg;
  logic [CW-1:0] line_len;
  logic          line_ok;
  err_vec_t      ev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {s_hs, s_vs, s_de, q_hs, q_vs, q_de} <= '0;
    end else begin
      {s_hs, s_vs, s_de} <= {hsync, vsync, de};
      {q_hs, q_vs, q_de} <= {s_hs, s_vs, s_de};
    end
  end

  assign hs_rise = s_hs && !q_hs;
  assign hs_edge = s_hs ^ q_hs;
  assign vs_rise = s_vs && !q_vs;
  assign vs_edge = s_vs ^ q_vs;
  assign de_rise = s_de && !q_de;
  assign de_fall = !s_de && q_de;
  assign de_chg  = s_de ^ q_de;
  assign meas_line_clks = line_len;

  ptm_hmeas #(.ACT_W(ACT_W), .LINE_MIN(LINE_MIN), .LINE_MAX(LINE_MAX), .CW(CW)) u_hmeas (
    .clk(clk), .rst_n(rst_n), .hs_rise(hs_rise), .de_lvl(s_de),
    .de_rise(de_rise), .de_fall(de_fall), .line_len(line_len), .line_ok(line_ok),
    .act_width(meas_act_width), .ev_line_chg(ev[E_LINE_CHG]),
    .ev_line_range(ev[E_LINE_RANGE]), .ev_act_w(ev[E_ACT_W]));

  ptm_vmeas #(.ACT_H(ACT_H), .FRAME_MIN(FRAME_MIN), .FRAME_MAX(FRAME_MAX),
              .CW(CW), .LW(LW), .FCW(FCW)) u_vmeas (
    .clk(clk), .rst_n(rst_n), .hs_rise(hs_rise), .vs_rise(vs_rise),
    .de_rise(de_rise), .line_len(line_len), .line_ok(line_ok),
    .frame_lines(meas_frame_lines), .act_height(meas_act_height),
    .ev_frame_range(ev[E_FRAME_RANGE]), .ev_act_h(ev[E_ACT_H]),
    .ev_vtime_chg(ev[E_VTIME_CHG]), .ev_vblank(ev[E_VBLANK]));

  ptm_setup #(.SETUP_MIN(SETUP_MIN)) u_setup (
    .clk(clk), .rst_n(rst_n), .vs_edge(vs_edge), .hs_edge(hs_edge),
    .ev_setup(ev[E_SETUP]));

  ptm_destuck #(.STUCK_CLKS(STUCK_CLKS)) u_destuck (
    .clk(clk), .rst_n(rst_n), .de_chg(de_chg), .ev_stuck(ev[E_DE_STUCK]));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_flags <= '0;
      err_pulse <= 1'b0;
    end else begin
      err_flags <= (clr ? '0 : err_flags) | ev;
      err_pulse <= |ev;
    end
  end

  a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((err_flags & $past(err_flags)) == $past(err_flags)));
  a_r11_pulse_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> (err_flags != '0));
  a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> ((err_flags == '0) == !err_pulse));
endmodule

// File: tb/test_panel_timing_monitor.sv
`timescale 1ns/1ps
module test_panel_timing_monitor;
  localparam int LMX = 20;
  localparam int FMX = 12;

  logic clk = 1'b0;
  logic rst_n, hsync, vsync, de, clr;
  logic [8:0] err_flags;
  logic       err_pulse;
  logic [5:0] meas_line_clks, meas_act_width;
  logic [4:0] meas_frame_lines, meas_act_height;

  int n_checks = 0;
  int n_fail   = 0;
  int pulse_cnt = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  panel_timing_monitor #(
    .ACT_W(8), .ACT_H(4), .LINE_MIN(16), .LINE_MAX(LMX),
    .FRAME_MIN(8), .FRAME_MAX(FMX), .SETUP_MIN(4), .STUCK_CLKS(200)
  ) i_panel_timing_monitor (
    .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync), .de(de), .clr(clr),
    .err_flags(err_flags), .err_pulse(err_pulse),
    .meas_line_clks(meas_line_clks), .meas_act_width(meas_act_width),
    .meas_frame_lines(meas_frame_lines), .meas_act_height(meas_act_height));

  always @(posedge clk) if (rst_n && err_pulse) pulse_cnt <= pulse_cnt + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; hsync = 1'b0; vsync = 1'b0; de = 1'b0; clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // one frame: hsync high at positions 0..1 of each line, vsync rises at vs_pos
  // of line 0 and falls at vs_pos of line 2
  task automatic gen_frame(input int len, input int lines, input int aw, input int vstart,
                           input int alines, input int de_off, input int vs_pos,
                           input int ext_line);
    for (int ln = 0; ln < lines; ln++) begin
      int ll;
      ll = len + ((ln == ext_line) ? 1 : 0);
      for (int p = 0; p < ll; p++) begin
        @(negedge clk);
        hsync = (p < 2);
        de    = (ln >= vstart) && (ln < vstart + alines) && (p >= de_off) && (p < de_off + aw);
        vsync = (ln == 0 && p >= vs_pos) || (ln == 1) || (ln == 2 && p < vs_pos);
      end
    end
  endtask

  task automatic settle();
    @(negedge clk); hsync = 1'b0; vsync = 1'b0; de = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk);
    chk("R1 flags", 32'(err_flags), 0);
    chk("R1 pulse", 32'(err_pulse), 0);
    chk("R1 meas", 32'({meas_line_clks, meas_act_width, meas_frame_lines, meas_act_height}), 0);
  endtask

  task automatic t_nominal();
    int p0;
    do_reset(); p0 = pulse_cnt;
    repeat (4) gen_frame(18, 10, 8, 3, 4, 4, 6, -1);
    settle();
    chk("R2 R3 R5 R7 R8 R9 R10 clean flags", 32'(err_flags), 0);
    chk("R11 no pulse", 32'(pulse_cnt - p0), 0);
    chk("R12 line clks", 32'(meas_line_clks), 18);
    chk("R12 act width", 32'(meas_act_width), 8);
    chk("R12 frame lines", 32'(meas_frame_lines), 10);
    chk("R12 act height", 32'(meas_act_height), 4);
  endtask

  task automatic t_line_range();
    do_reset();
    repeat (4) gen_frame(24, 10, 8, 3, 4, 4, 6, -1);
    settle();
    chk("R3 long line", 32'(err_flags), 32'h002);
    chk("R12 long line clks", 32'(meas_line_clks), 24);
    do_reset();
    repeat (4) gen_frame(14, 10, 8, 3, 4, 4, 6, -1);
    settle();
    chk("R3 short line", 32'(err_flags), 32'h002);
  endtask

  task automatic t_line_change();
    do_reset();
    repeat (2) gen_frame(18, 10, 8, 3, 4, 4, 6, -1);
    gen_frame(18, 10, 8, 3, 4, 4, 6, 1);
    gen_frame(18, 10, 8, 3, 4, 4, 6, -1);
    settle();
    chk("R2 line change", 32'(err_flags[0]), 1);
    chk("R7 frame clocks change", 32'(err_flags[3]), 1);
    chk("R3 no range fault", 32'(err_flags[1]), 0);
  endtask

  task automatic t_width();
    do_reset();
    repeat (4) gen_frame(18, 10, 7, 3, 4, 4, 6, -1);
    settle();
    chk("R4 width 7", 32'(err_flags), 32'h080);
    chk("R12 width value", 32'(meas_act_width), 7);
  endtask

  task automatic t_height();
    do_reset();
    repeat (4) gen_frame(18, 10, 8, 3, 5, 4, 6, -1);
    settle();
    chk("R6 height 5", 32'(err_flags), 32'h100);
    chk("R12 height value", 32'(meas_act_height), 5);
  endtask

  task automatic t_frame_range();
    do_reset();
    repeat (4) gen_frame(18, 14, 8, 3, 4, 4, 6, -1);
    settle();
    chk("R5 frame long", 32'(err_flags), 32'h004);
    chk("R12 frame lines 14", 32'(meas_frame_lines), 14);
    do_reset();
    repeat (4) gen_frame(18, 7, 8, 3, 4, 4, 6, -1);
    settle();
    chk("R5 frame short", 32'(err_flags), 32'h004);
  endtask

  task automatic t_vds();
    do_reset();
    repeat (2) gen_frame(18, 10, 8, 3, 4, 4, 6, -1);
    gen_frame(18, 10, 8, 2, 4, 4, 6, -1);
    gen_frame(18, 10, 8, 3, 4, 4, 6, -1);
    settle();
    chk("R7 sync-to-active change", 32'(err_flags), 32'h008);
  endtask

  task automatic t_vblank();
    int p0;
    do_reset(); p0 = pulse_cnt;
    repeat (2) gen_frame(18, 10, 8, 3, 4, 4, 6, -1);
    gen_frame(18, 10, 8, 3, 4, 5, 6, -1);
    gen_frame(18, 10, 8, 3, 4, 4, 6, -1);
    settle();
    chk("R8 fractional blanking", 32'(err_flags), 32'h010);
    chk("R11 pulse per fault", 32'(pulse_cnt - p0), 2);
  endtask

  task automatic t_setup();
    do_reset();
    repeat (4) gen_frame(18, 10, 8, 3, 4, 4, 16, -1);
    settle();
    chk("R9 setup short", 32'(err_flags), 32'h020);
  endtask

  task automatic t_stuck_clear();
    int p0;
    do_reset(); p0 = pulse_cnt;
    gen_frame(18, 12, 8, 0, 0, 4, 6, -1);
    settle();
    chk("R10 stuck low", 32'(err_flags), 32'h040);
    chk("R10 single pulse", 32'(pulse_cnt - p0), 1);
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    repeat (2) @(negedge clk);
    chk("R11 clear", 32'(err_flags), 0);
    repeat (20) @(negedge clk);
    chk("R10 no refire while stuck", 32'(err_flags), 0);
    chk("R10 pulse count after clear", 32'(pulse_cnt - p0), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_nominal();
    t_line_range();
    t_line_change();
    t_width();
    t_height();
    t_frame_range();
    t_vds();
    t_vblank();
    t_setup();
    t_stuck_clear();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule